// File: doc/BRIEF.md
# Transmit Buffer Ownership Tracker

This block tracks who owns each of a set of transmit packet buffers shared by two controllers: an upper controller that fills buffers and a lower controller that sends them. Every buffer carries a three-bit ownership code. Each controller asks to move one buffer to a new code through its own request port. The tracker checks the request against a fixed table of transitions, where each transition belongs to exactly one controller. It then answers with accept or reject one cycle later.

Two notification pulses stand in for the messages between the controllers. A "frame ready" pulse follows an upper hand-off to the lower side. A "frame done" pulse follows a completed transmission. The tracker also caps how many buffers the lower side may hold at once, at two by default. This lets the upper controller prepare the next frame while one is in flight and another waits, which gives a pipelined ping-pong scheme. Every buffer's code can be read back at all times.

Both request ports are valid/ready. A request is taken on a clock edge where valid and ready are both high. The requester must hold index and target stable while valid is high and ready is low. The lower port is never stalled. The upper port is stalled for one cycle when both ports name the same buffer. The responses carry no back-pressure.

Top module: `txbuf_owner_tracker`

## Requirements
- R1: After reset every buffer reads code 0 (UNINIT), no pulse or response is active and the error flag is 0. No accepted request ever returns a buffer to code 0, and any request targeting code 0 is rejected.
- R2: The codes are 0 UNINIT, 1 HIGH, 2 LOW, 3 READY and 4 DONE. Buffer i is read back on `buf_state[3*i+2:3*i]`. The upper port may move UNINIT to HIGH (this is the initialisation command), HIGH to READY, and DONE to HIGH. An accepted request updates the readback on the same edge, and `up_rsp_valid`/`up_rsp_ok` follow in the next cycle.
- R3: The lower port may move READY to LOW and LOW to DONE, with the same timing.
- R4: An accepted HIGH to READY request produces a one-cycle `ready_pulse` carrying that buffer's index in the response cycle. A lower request can only find a buffer in READY once that pulse has been issued.
- R5: An accepted LOW to DONE request produces a one-cycle `done_pulse` carrying that buffer's index in the response cycle.
- R6: Any other request is rejected: the wrong port, the wrong source code, or an undefined target. The buffer's code stays unchanged and `err_flag` is set. The flag stays set until reset.
- R7: At no time are more than LOW_LIMIT (2) buffers in READY or LOW together. A HIGH to READY request that would exceed this is rejected.
- R8: When both ports present requests for the same buffer in one cycle, the lower request is served and `up_req_ready` is low. The held upper request is checked in the next cycle against the updated code.
- R9: A buffer may go to READY while other buffers sit in DONE. DONE buffers do not count toward the limit.
- R10: `lo_req_ready` is always 1 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req_valid | input | 1 | Upper request valid |
| up_req_ready | output | 1 | Upper request accepted this edge |
| up_req_idx | input | 3 | Upper request buffer index |
| up_req_tgt | input | 3 | Upper request target code |
| up_rsp_valid | output | 1 | Upper response valid |
| up_rsp_ok | output | 1 | Upper request was legal |
| lo_req_valid | input | 1 | Lower request valid |
| lo_req_ready | output | 1 | Lower request ready (always 1) |
| lo_req_idx | input | 3 | Lower request buffer index |
| lo_req_tgt | input | 3 | Lower request target code |
| lo_rsp_valid | output | 1 | Lower response valid |
| lo_rsp_ok | output | 1 | Lower request was legal |
| ready_pulse | output | 1 | Frame-ready notification |
| ready_idx | output | 3 | Buffer index of frame-ready |
| done_pulse | output | 1 | Frame-done notification |
| done_idx | output | 3 | Buffer index of frame-done |
| err_flag | output | 1 | Sticky illegal-request flag |
| buf_state | output | 24 | Ownership codes, 3 bits per buffer |

## Verification
A wrong stored code shows on the readback on the very edge it is written. It also changes the verdict of the next request that names that buffer, so a reply arrives with the wrong `ok` one cycle later. A wrong occupancy count shows up as a third READY being accepted, or a legal one being refused, when the next hand-off is requested. A lost or misrouted notification is caught because every expected pulse index is queued and must be consumed by the end.

// File: rtl/txo_pkg.sv
package txo_pkg;
  localparam int ST_W = 3;
  typedef enum logic [ST_W-1:0] {
    ST_UNINIT = 3'd0,
    ST_HIGH   = 3'd1,
    ST_LOW    = 3'd2,
    ST_READY  = 3'd3,
    ST_DONE   = 3'd4
  } own_st_e;
endpackage

// File: rtl/txo_rule.sv
module txo_rule
  import txo_pkg::*;
#(
  parameter bit IS_UPPER = 1'b1
) (
  input  logic [ST_W-1:0] cur_st,
  input  logic [ST_W-1:0] tgt_st,
  input  logic            room,
  output logic            legal
);
  generate
    if (IS_UPPER) begin : g_up
      always_comb begin
        legal = 1'b0;
        if (cur_st == ST_UNINIT && tgt_st == ST_HIGH)       legal = 1'b1;
        else if (cur_st == ST_HIGH && tgt_st == ST_READY)   legal = room;
        else if (cur_st == ST_DONE && tgt_st == ST_HIGH)    legal = 1'b1;
      end
    end else begin : g_lo
      always_comb begin
        legal = 1'b0;
        if (cur_st == ST_READY && tgt_st == ST_LOW)         legal = 1'b1;
        else if (cur_st == ST_LOW && tgt_st == ST_DONE)     legal = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/txo_occupancy.sv
module txo_occupancy
  import txo_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int CNT_W   = $clog2(NUM_BUF + 1)
) (
  input  logic [NUM_BUF*ST_W-1:0] state_flat,
  output logic [CNT_W-1:0]        busy_cnt
);
  always_comb begin
    busy_cnt = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (state_flat[i*ST_W +: ST_W] == ST_READY ||
          state_flat[i*ST_W +: ST_W] == ST_LOW)
        busy_cnt = busy_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/txo_state_bank.sv
module txo_state_bank
  import txo_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lo_we,
  input  logic [IDX_W-1:0]        lo_idx,
  input  logic [ST_W-1:0]         lo_tgt,
  input  logic                    up_we,
  input  logic [IDX_W-1:0]        up_idx,
  input  logic [ST_W-1:0]         up_tgt,
  output logic [NUM_BUF*ST_W-1:0] state_flat
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic [ST_W-1:0] st_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   st_q <= ST_UNINIT;
      else if (lo_we && lo_idx == IDX_W'(i))        st_q <= lo_tgt;
      else if (up_we && up_idx == IDX_W'(i))        st_q <= up_tgt;
    end
    assign state_flat[i*ST_W +: ST_W] = st_q;
  end
endmodule

// File: rtl/txbuf_owner_tracker.sv
module txbuf_owner_tracker
  import txo_pkg::*;
#(
  parameter int NUM_BUF   = 8,
  parameter int LOW_LIMIT = 2,
  localparam int IDX_W    = $clog2(NUM_BUF),
  localparam int CNT_W    = $clog2(NUM_BUF + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    up_req_valid,
  output logic                    up_req_ready,
  input  logic [IDX_W-1:0]        up_req_idx,
  input  logic [ST_W-1:0]         up_req_tgt,
  output logic                    up_rsp_valid,
  output logic                    up_rsp_ok,
  input  logic                    lo_req_valid,
  output logic                    lo_req_ready,
  input  logic [IDX_W-1:0]        lo_req_idx,
  input  logic [ST_W-1:0]         lo_req_tgt,
  output logic                    lo_rsp_valid,
  output logic                    lo_rsp_ok,
  output logic                    ready_pulse,
  output logic [IDX_W-1:0]        ready_idx,
  output logic                    done_pulse,
  output logic [IDX_W-1:0]        done_idx,
  output logic                    err_flag,
  output logic [NUM_BUF*ST_W-1:0] buf_state
);
  logic [CNT_W-1:0] busy_cnt;
  logic             room;
  logic [ST_W-1:0]  up_cur, lo_cur;
  logic             up_legal, lo_legal;
  logic             up_fire, up_we, lo_we;

  // lower side wins a same-buffer collision; upper is held off one cycle
  assign lo_req_ready = rst_n;
  assign up_req_ready = !(lo_req_valid && lo_req_idx == up_req_idx);
  assign up_fire      = up_req_valid && up_req_ready;

  assign up_cur = buf_state[up_req_idx*ST_W +: ST_W];
  assign lo_cur = buf_state[lo_req_idx*ST_W +: ST_W];
  assign room   = busy_cnt < CNT_W'(LOW_LIMIT);

  txo_occupancy #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W)) occ_i (
    .state_flat (buf_state),
    .busy_cnt   (busy_cnt)
  );

  txo_rule #(.IS_UPPER(1'b1)) up_rule_i (
    .cur_st (up_cur), .tgt_st (up_req_tgt), .room (room), .legal (up_legal)
  );

  txo_rule #(.IS_UPPER(1'b0)) lo_rule_i (
    .cur_st (lo_cur), .tgt_st (lo_req_tgt), .room (room), .legal (lo_legal)
  );

  assign up_we = up_fire && up_legal;
  assign lo_we = lo_req_valid && lo_legal;

  txo_state_bank #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) bank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_we      (lo_we),
    .lo_idx     (lo_req_idx),
    .lo_tgt     (lo_req_tgt),
    .up_we      (up_we),
    .up_idx     (up_req_idx),
    .up_tgt     (up_req_tgt),
    .state_flat (buf_state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_rsp_valid <= 1'b0;
      up_rsp_ok    <= 1'b0;
      lo_rsp_valid <= 1'b0;
      lo_rsp_ok    <= 1'b0;
      ready_pulse  <= 1'b0;
      ready_idx    <= '0;
      done_pulse   <= 1'b0;
      done_idx     <= '0;
      err_flag     <= 1'b0;
    end else begin
      up_rsp_valid <= up_fire;
      up_rsp_ok    <= up_we;
      lo_rsp_valid <= lo_req_valid;
      lo_rsp_ok    <= lo_we;
      ready_pulse  <= up_we && up_req_tgt == ST_READY;
      ready_idx    <= up_req_idx;
      done_pulse   <= lo_we && lo_req_tgt == ST_DONE;
      done_idx     <= lo_req_idx;
      err_flag     <= err_flag || (up_fire && !up_legal) ||
                      (lo_req_valid && !lo_legal);
    end
  end
endmodule

// File: rtl/txo_checker.sv
module txo_checker
  import txo_pkg::*;
#(
  parameter int NUM_BUF   = 8,
  parameter int LOW_LIMIT = 2,
  localparam int IDX_W    = $clog2(NUM_BUF)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    up_req_valid,
  input logic                    up_req_ready,
  input logic [IDX_W-1:0]        up_req_idx,
  input logic                    up_rsp_valid,
  input logic                    lo_req_valid,
  input logic                    lo_req_ready,
  input logic [IDX_W-1:0]        lo_req_idx,
  input logic                    ready_pulse,
  input logic [IDX_W-1:0]        ready_idx,
  input logic                    done_pulse,
  input logic [IDX_W-1:0]        done_idx,
  input logic                    err_flag,
  input logic [NUM_BUF*ST_W-1:0] buf_state
);
  function automatic int count_busy(input logic [NUM_BUF*ST_W-1:0] f);
    int n = 0;
    for (int i = 0; i < NUM_BUF; i++)
      if (f[i*ST_W +: ST_W] == ST_READY || f[i*ST_W +: ST_W] == ST_LOW) n++;
    return n;
  endfunction

  a_r7_busy_limit: assert property (@(posedge clk) disable iff (!rst_n)
    count_busy(buf_state) <= LOW_LIMIT);

  a_r4_ready_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse |-> buf_state[ready_idx*ST_W +: ST_W] == ST_READY);

  a_r5_done_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> buf_state[done_idx*ST_W +: ST_W] == ST_DONE);

  a_r8_collision_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_req_valid && up_req_valid && lo_req_idx == up_req_idx) |-> !up_req_ready);

  a_r2_upper_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_valid && up_req_ready) |=> up_rsp_valid);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r10_lower_ready: assert property (@(posedge clk) disable iff (!rst_n)
    lo_req_ready);

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_nz
    a_r1_no_return_uninit: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_state[i*ST_W +: ST_W] != ST_UNINIT) |=> (buf_state[i*ST_W +: ST_W] != ST_UNINIT));
  end
endmodule

bind txbuf_owner_tracker txo_checker #(.NUM_BUF(NUM_BUF), .LOW_LIMIT(LOW_LIMIT)) chk_i (.*);

// File: tb/txbuf_owner_tracker_tb_top.sv
module txbuf_owner_tracker_tb_top;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req_valid = 1'b0, lo_req_valid = 1'b0;
  logic [2:0] up_req_idx = '0, up_req_tgt = '0, lo_req_idx = '0, lo_req_tgt = '0;
  logic up_req_ready, lo_req_ready, up_rsp_valid, up_rsp_ok, lo_rsp_valid, lo_rsp_ok;
  logic ready_pulse, done_pulse, err_flag;
  logic [2:0] ready_idx, done_idx;
  logic [NB*3-1:0] buf_state;

  int checks = 0, fails = 0;
  bit up_q[$], lo_q[$];
  int rdy_q[$], done_q[$];

  always #4 clk = ~clk;

  txbuf_owner_tracker dut_i (.*);

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_st(input int idx, input int exp, input string tag);
    check(buf_state[idx*3 +: 3] == 3'(exp), tag, int'(buf_state[idx*3 +: 3]), exp);
  endtask

  // driver: one upper and/or lower request, expected verdicts pushed to scoreboard
  task automatic issue(input bit du, input int ui, input int ut, input bit ue,
                       input bit dl, input int li, input int lt, input bit le);
    bit up_done = !du;
    @(negedge clk);
    up_req_valid = du; up_req_idx = 3'(ui); up_req_tgt = 3'(ut);
    lo_req_valid = dl; lo_req_idx = 3'(li); lo_req_tgt = 3'(lt);
    if (dl) begin
      lo_q.push_back(le);
      if (le && lt == 4) done_q.push_back(li);
      #1 check(lo_req_ready == 1'b1, "R10 lower ready", int'(lo_req_ready), 1);
    end
    if (du && dl && ui == li) begin
      #1 check(up_req_ready == 1'b0, "R8 collision stall", int'(up_req_ready), 0);
    end
    do begin
      #1;
      if (du && !up_done && up_req_ready) begin
        up_done = 1'b1;
        up_q.push_back(ue);
        if (ue && ut == 3) rdy_q.push_back(ui);
      end
      @(negedge clk);
      lo_req_valid = 1'b0;
    end while (!up_done);
    up_req_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares responses and pulses against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (up_rsp_valid) begin
        if (up_q.size() == 0) check(0, "R2 unexpected upper reply", 1, 0);
        else begin
          automatic bit e = up_q.pop_front();
          check(up_rsp_ok == e, "R2/R6/R7 upper verdict", int'(up_rsp_ok), int'(e));
        end
      end
      if (lo_rsp_valid) begin
        if (lo_q.size() == 0) check(0, "R3 unexpected lower reply", 1, 0);
        else begin
          automatic bit e = lo_q.pop_front();
          check(lo_rsp_ok == e, "R3/R6 lower verdict", int'(lo_rsp_ok), int'(e));
        end
      end
      if (ready_pulse) begin
        if (rdy_q.size() == 0) check(0, "R4 unexpected ready pulse", int'(ready_idx), -1);
        else begin
          automatic int e = rdy_q.pop_front();
          check(int'(ready_idx) == e, "R4 ready index", int'(ready_idx), e);
        end
      end
      if (done_pulse) begin
        if (done_q.size() == 0) check(0, "R5 unexpected done pulse", int'(done_idx), -1);
        else begin
          automatic int e = done_q.pop_front();
          check(int'(done_idx) == e, "R5 done index", int'(done_idx), e);
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NB; i++) check_st(i, 0, "R1 reset code");
    check(!err_flag && !ready_pulse && !done_pulse && !up_rsp_valid, "R1 reset outputs", int'(err_flag), 0);

    // R6 lower acting on an uninitialised buffer
    issue(0, 0, 0, 0, 1, 0, 2, 0);
    check_st(0, 0, "R6 state kept");
    check(err_flag == 1'b1, "R6 error flag", int'(err_flag), 1);

    // R2 initialisation of buffers 0..3
    for (int i = 0; i < 4; i++) issue(1, i, 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) check_st(i, 1, "R2 init to HIGH");
    // R1 target UNINIT refused
    issue(1, 0, 0, 0, 0, 0, 0, 0);
    check_st(0, 1, "R1 no return to UNINIT");

    // R4 hand two buffers to the lower side; R7 third refused
    issue(1, 0, 3, 1, 0, 0, 0, 0);
    issue(1, 1, 3, 1, 0, 0, 0, 0);
    issue(1, 2, 3, 0, 0, 0, 0, 0);
    check_st(2, 1, "R7 over-limit buffer stays HIGH");

    // R6 upper attempting a lower transition
    issue(1, 0, 2, 0, 0, 0, 0, 0);
    check_st(0, 3, "R6 wrong agent no effect");

    // R3 / R5 lower takes and finishes buffer 0
    issue(0, 0, 0, 0, 1, 0, 2, 1);
    check_st(0, 2, "R3 READY to LOW");
    issue(0, 0, 0, 0, 1, 0, 4, 1);
    check_st(0, 4, "R5 LOW to DONE");

    // R9 new hand-off while buffer 0 waits in DONE
    issue(1, 2, 3, 1, 0, 0, 0, 0);
    check_st(2, 3, "R9 READY beside DONE");
    check_st(0, 4, "R9 DONE untouched");

    // R8 collision on buffer 1: lower LOW->DONE first, then upper DONE->HIGH
    issue(0, 0, 0, 0, 1, 1, 2, 1);
    issue(1, 1, 1, 1, 1, 1, 4, 1);
    check_st(1, 1, "R8 upper rechecked after lower");
    issue(1, 0, 1, 1, 0, 0, 0, 0);
    check_st(0, 1, "R2 DONE to HIGH");

    // final readback
    check_st(2, 3, "R7 final buffer 2");
    check_st(3, 1, "R2 final buffer 3");
    for (int i = 4; i < NB; i++) check_st(i, 0, "R1 untouched buffers");
    repeat (3) @(negedge clk);
    check(up_q.size() == 0 && lo_q.size() == 0, "R2/R3 replies all seen", up_q.size() + lo_q.size(), 0);
    check(rdy_q.size() == 0, "R4 ready pulses all seen", rdy_q.size(), 0);
    check(done_q.size() == 0, "R5 done pulses all seen", done_q.size(), 0);
    summary();
  end
endmodule